// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Register Interface

This block is a countdown watchdog that host software drives through a small synchronous register port. Software programs an initial tick count, forces the counter back to that count (the "kick"), starts or halts counting, reads the ticks remaining and clears sticky status flags. An external one-cycle tick-enable pulse advances the counter. One tick is meant to last 0.6 s, so a timeout of S seconds is programmed as S*10/6 ticks. The reset default is 50 ticks, which is 30 s.

Escalation has two stages. The first expiry does not request a reset. It sets a timeout status flag, emits a one-cycle event pulse, reloads the counter from the initial value and keeps counting. If the counter expires again while that flag is still set, the block sets a second-timeout flag. In the same cycle it raises a level reset request, unless a no-reboot gate bit is set. Software that services the watchdog clears the timeout flag and kicks the counter, and the full two-expiry sequence then starts again. Generating the tick period, bridging to a system bus and the reset circuitry itself are left to neighbouring logic.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the counter is halted, the no-reboot gate is set (control word reads 0x0801), all status flags read 0, the reset request is low, and the count and initial value both read the reset default (50).
- R2: Any write to the count register (address 0) loads the counter with the initial value. A read of address 0 returns the current count in bits 9:0, with the upper bits zero.
- R3: The initial-value register (address 1) holds the tick count in bits 9:0 and six plain storage bits in 15:10. A write whose resulting 10-bit count is below 4 leaves the old count in place but still updates the upper bits. Byte enable 0 gates bits 7:0 and byte enable 1 gates bits 15:8 of every write.
- R4: Control bit 11 (address 2) halts the counter when 1. While it is set, ticks leave the count unchanged.
- R5: While running, each tick pulse lowers the count by exactly one.
- R6: The tick that would bring the count from 1 to 0 is an expiry. It reloads the count from the initial value and, if status bit 3 of address 3 is clear, sets that bit and pulses the event output high for exactly one cycle.
- R7: An expiry while status bit 3 is already set sets bit 1 of address 4. With the no-reboot gate clear, the same edge raises the reset request and sets bit 2 of address 4 (boot flag).
- R8: Control bit 0 (address 2) is the no-reboot gate. While it is 1, a second expiry still sets bit 1 of address 4, but the reset request stays low and bit 2 is not set. Writing it to 0 reads back as 0.
- R9: Status bits at addresses 3 and 4 are write-one-to-clear. Writing 0, or writing 1 through a disabled byte lane, leaves them set.
- R10: After the timeout flag is cleared and the counter is kicked, the next expiry is again a first-stage expiry: an event pulse and no reset request.
- R11: A count-register write and a tick in the same cycle resolve to the reload. No decrement and no expiry occur.
- R12: Once raised, the reset request stays high until the block reset, which clears it.
- R13: Read data and a valid strobe appear one cycle after a read request. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable pulse, one per tick period |
| bus_addr | input | ADDR_W (3) | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | DATA_W/8 (2) | Byte enables for writes |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data |
| bus_rvalid | output | 1 | High the cycle after a read request |
| first_evt_o | output | 1 | One-cycle pulse on a first-stage expiry |
| sys_rst_req_o | output | 1 | Level reset request after a second expiry |

## Verification
The hardest state to reach from the ports is a second expiry, because it needs two full countdowns with the status flag left untouched in between. A single kick-and-clear in the wrong place silently restarts the sequence. The bench therefore sweeps small initial values and both settings of the no-reboot gate. For each combination it programs the count, runs exactly N-1 ticks, then the expiring tick, then a further N ticks, and predicts the count, the flags and the reset level arithmetically at each step. The same-cycle collision of a kick with the expiring tick is forced by lining up the write strobe and the tick on one edge when the count is 1.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Register word addresses
  localparam int ADR_COUNT = 0;
  localparam int ADR_INIT  = 1;
  localparam int ADR_CTRL  = 2;
  localparam int ADR_STS1  = 3;
  localparam int ADR_STS2  = 4;

  // Bit positions software decodes
  localparam int HALT_BIT     = 11;
  localparam int NOREBOOT_BIT = 0;
  localparam int TO_BIT       = 3;
  localparam int SECOND_BIT   = 1;
  localparam int BOOT_BIT     = 2;

  // Write-one-to-clear strobes for the sticky flags
  typedef struct packed {
    logic to;
    logic second;
    logic boot;
  } wdt_clr_t;
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int INIT_RST = 50,
  parameter int MIN_INIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  output logic [CNT_W-1:0]    init_val,
  output logic [DATA_W-1:0]   init_word,
  output logic [DATA_W-1:0]   ctrl_word,
  output logic                halt,
  output logic                noreboot,
  output logic                reload,
  output wdt_clr_t            clr
);
  localparam int NB   = DATA_W / 8;
  localparam int HI_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] bmask;
  logic [DATA_W-1:0] wd_m;
  logic [DATA_W-1:0] init_next;
  logic [DATA_W-1:0] ctrl_next;
  logic [HI_W-1:0]   init_hi;
  logic              sel_count, sel_init, sel_ctrl, sel_sts1, sel_sts2;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign bmask[b*8 +: 8] = {8{be[b]}};
  end

  assign wd_m      = wdata & bmask;
  assign sel_count = wr && (addr == ADDR_W'(ADR_COUNT));
  assign sel_init  = wr && (addr == ADDR_W'(ADR_INIT));
  assign sel_ctrl  = wr && (addr == ADDR_W'(ADR_CTRL));
  assign sel_sts1  = wr && (addr == ADDR_W'(ADR_STS1));
  assign sel_sts2  = wr && (addr == ADDR_W'(ADR_STS2));

  assign init_word = {init_hi, init_val};

  always_comb begin
    ctrl_word               = '0;
    ctrl_word[HALT_BIT]     = halt;
    ctrl_word[NOREBOOT_BIT] = noreboot;
  end

  assign init_next = wd_m | (init_word & ~bmask);
  assign ctrl_next = wd_m | (ctrl_word & ~bmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_val <= CNT_W'(INIT_RST);
      init_hi  <= '0;
      halt     <= 1'b1;
      noreboot <= 1'b1;
    end else begin
      if (sel_init) begin
        init_hi <= init_next[DATA_W-1:CNT_W];
        if (init_next[CNT_W-1:0] >= CNT_W'(MIN_INIT))
          init_val <= init_next[CNT_W-1:0];
      end
      if (sel_ctrl) begin
        halt     <= ctrl_next[HALT_BIT];
        noreboot <= ctrl_next[NOREBOOT_BIT];
      end
    end
  end

  assign reload     = sel_count;
  assign clr.to     = sel_sts1 && wd_m[TO_BIT];
  assign clr.second = sel_sts2 && wd_m[SECOND_BIT];
  assign clr.boot   = sel_sts2 && wd_m[BOOT_BIT];
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic step;
  logic last;

  assign step   = tick && !halt && !reload;
  assign last   = (cnt <= CNT_W'(1));
  assign expire = step && last;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= CNT_W'(INIT_RST);
    else if (reload)
      cnt <= init_val;
    else if (step)
      cnt <= last ? init_val : cnt - CNT_W'(1);
  end
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     expire,
  input  logic     noreboot,
  input  wdt_clr_t clr,
  output logic     sts_to,
  output logic     sts_2nd,
  output logic     sts_boot,
  output logic     event_o,
  output logic     reset_req
);
  logic second_hit;
  logic fire;

  assign second_hit = expire && sts_to;
  assign fire       = second_hit && !noreboot;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_to    <= 1'b0;
      sts_2nd   <= 1'b0;
      sts_boot  <= 1'b0;
      event_o   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      event_o <= expire && !sts_to;
      if (expire)      sts_to <= 1'b1;
      else if (clr.to) sts_to <= 1'b0;
      if (second_hit)      sts_2nd <= 1'b1;
      else if (clr.second) sts_2nd <= 1'b0;
      if (fire)          sts_boot <= 1'b1;
      else if (clr.boot) sts_boot <= 1'b0;
      if (fire) reset_req <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int INIT_RST = 50,
  parameter int MIN_INIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic                first_evt_o,
  output logic                sys_rst_req_o
);
  logic [CNT_W-1:0]  w_init;
  logic [DATA_W-1:0] w_init_word, w_ctrl_word;
  logic              w_halt, w_noreboot, w_reload;
  wdt_clr_t          w_clr;
  logic [CNT_W-1:0]  w_cnt;
  logic              w_expire;
  logic              w_sts_to, w_sts_2nd, w_sts_boot;
  logic [DATA_W-1:0] sts1_word, sts2_word, rd_mux;

  wdt_cfg_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .INIT_RST(INIT_RST), .MIN_INIT(MIN_INIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .be(bus_be),
    .wdata(bus_wdata), .init_val(w_init), .init_word(w_init_word),
    .ctrl_word(w_ctrl_word), .halt(w_halt), .noreboot(w_noreboot),
    .reload(w_reload), .clr(w_clr)
  );

  wdt_down_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .halt(w_halt), .reload(w_reload),
    .init_val(w_init), .cnt(w_cnt), .expire(w_expire)
  );

  wdt_escalate u_esc (
    .clk(clk), .rst(rst), .expire(w_expire), .noreboot(w_noreboot),
    .clr(w_clr), .sts_to(w_sts_to), .sts_2nd(w_sts_2nd),
    .sts_boot(w_sts_boot), .event_o(first_evt_o), .reset_req(sys_rst_req_o)
  );

  always_comb begin
    sts1_word             = '0;
    sts1_word[TO_BIT]     = w_sts_to;
    sts2_word             = '0;
    sts2_word[SECOND_BIT] = w_sts_2nd;
    sts2_word[BOOT_BIT]   = w_sts_boot;
    case (bus_addr)
      ADDR_W'(ADR_COUNT): rd_mux = DATA_W'(w_cnt);
      ADDR_W'(ADR_INIT):  rd_mux = w_init_word;
      ADDR_W'(ADR_CTRL):  rd_mux = w_ctrl_word;
      ADDR_W'(ADR_STS1):  rd_mux = sts1_word;
      ADDR_W'(ADR_STS2):  rd_mux = sts2_word;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/wdt_twostage_chk.sv
module wdt_twostage_chk #(
  parameter int CNT_W    = 10,
  parameter int MIN_INIT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd,
  input logic             rvalid,
  input logic             reset_req,
  input logic             event_o,
  input logic             sts_to,
  input logic             sts_2nd,
  input logic             halt,
  input logic             reload,
  input logic             noreboot,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_val
);
  p_init_floor_r3: assert property (@(posedge clk) disable iff (rst)
    init_val >= CNT_W'(MIN_INIT));

  p_halt_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (halt && !reload) |=> $stable(cnt));

  p_event_single_r6: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o);

  p_event_flag_r6: assert property (@(posedge clk) disable iff (rst)
    event_o |-> sts_to);

  p_req_with_second_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> (sts_2nd && $past(sts_to)));

  p_veto_r8: assert property (@(posedge clk) disable iff (rst)
    (noreboot && !reset_req) |=> !reset_req);

  p_req_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> reset_req);

  p_rvalid_r13: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);

  p_no_rvalid_r13: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);
endmodule

bind wdog_twostage wdt_twostage_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
  .clk(clk), .rst(rst), .rd(bus_rd), .rvalid(bus_rvalid),
  .reset_req(sys_rst_req_o), .event_o(first_evt_o), .sts_to(w_sts_to),
  .sts_2nd(w_sts_2nd), .halt(w_halt), .reload(w_reload),
  .noreboot(w_noreboot), .cnt(w_cnt), .init_val(w_init)
);

// File: tb/sim_wdog_twostage.sv
`timescale 1ns/1ps
module sim_wdog_twostage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_be = 2'b11;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        first_evt_o;
  logic        sys_rst_req_o;

  int nvec = 0;
  int nbad = 0;
  logic [15:0] rv;

  wdog_twostage u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .first_evt_o(first_evt_o), .sys_rst_req_o(sys_rst_req_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int a, input int d, input logic [1:0] be);
    bus_addr = 3'(a); bus_wdata = 16'(d); bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b11;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_addr = 3'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(2, rv); chk("R1 ctrl", rv, 16'h0801);
    rd(3, rv); chk("R1 sts1", rv, 0);
    rd(4, rv); chk("R1 sts2", rv, 0);
    rd(0, rv); chk("R1 count", rv, 50);
    rd(1, rv); chk("R1 init", rv, 50);
    chk("R1 req", sys_rst_req_o, 0);

    // R4 halted counter ignores ticks
    ticks(5);
    rd(0, rv); chk("R4 halted count", rv, 50);

    // R13 read valid timing and unmapped address
    bus_addr = 3'd7; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R13 rvalid", bus_rvalid, 1);
    chk("R13 unmapped", bus_rdata, 0);
    @(negedge clk);
    chk("R13 rvalid drop", bus_rvalid, 0);

    // R3 initial-value field rules
    wr(1, 7, 2'b11);
    for (int v = 0; v < 4; v++) begin
      wr(1, v, 2'b11);
      rd(1, rv); chk("R3 small ignored", rv, 7);
    end
    wr(1, 16'hFC07, 2'b11); rd(1, rv); chk("R3 upper kept", rv, 16'hFC07);
    wr(1, 16'hA802, 2'b11); rd(1, rv); chk("R3 upper with small", rv, 16'hA807);
    wr(1, 16'h0009, 2'b01); rd(1, rv); chk("R3 low lane", rv, 16'hA809);
    wr(1, 16'h0100, 2'b10); rd(1, rv); chk("R3 high lane", rv, 16'h0109);

    // R8 gate write reads back cleared
    wr(2, 0, 2'b11); rd(2, rv); chk("R8 gate cleared", rv, 0);

    // Sweep: initial value and gate setting
    for (int nr = 0; nr < 2; nr++) begin
      for (int n = 4; n < 10; n++) begin
        do_reset();
        wr(2, nr, 2'b11);
        wr(1, n, 2'b11);
        wr(0, 16'h1234, 2'b11);
        rd(0, rv); chk("R2 reload", rv, n);
        ticks(n - 1);
        chk("R6 no early event", first_evt_o, 0);
        rd(0, rv); chk("R5 decrement", rv, 1);
        ticks(1);
        chk("R6 event", first_evt_o, 1);
        @(negedge clk);
        chk("R6 event pulse", first_evt_o, 0);
        rd(3, rv); chk("R6 sts1", rv, 16'h0008);
        rd(0, rv); chk("R6 auto reload", rv, n);
        chk("R6 no req yet", sys_rst_req_o, 0);
        ticks(n);
        chk(nr ? "R8 req vetoed" : "R7 req raised", sys_rst_req_o, nr ? 0 : 1);
        rd(4, rv); chk(nr ? "R8 sts2" : "R7 sts2", rv, nr ? 16'h0002 : 16'h0006);
        ticks(n + 2);
        chk("R12 req level", sys_rst_req_o, nr ? 0 : 1);
        do_reset();
        chk("R12 req cleared", sys_rst_req_o, 0);
      end
    end

    // R9 write-one-to-clear and R10 restart of the sequence
    do_reset();
    wr(2, 0, 2'b11);
    wr(1, 4, 2'b11);
    wr(0, 0, 2'b11);
    ticks(4);
    wr(3, 0, 2'b11);        rd(3, rv); chk("R9 zero write", rv, 16'h0008);
    wr(3, 16'h0008, 2'b10); rd(3, rv); chk("R9 lane off", rv, 16'h0008);
    wr(3, 16'h0008, 2'b01); rd(3, rv); chk("R9 cleared", rv, 0);
    wr(0, 0, 2'b11);
    ticks(4);
    chk("R10 first again", first_evt_o, 1);
    chk("R10 no req", sys_rst_req_o, 0);
    rd(4, rv); chk("R10 sts2 clear", rv, 0);
    ticks(4);
    rd(4, rv); chk("R9 sts2 set", rv, 16'h0006);
    wr(4, 16'h0002, 2'b11); rd(4, rv); chk("R9 second cleared", rv, 16'h0004);
    wr(4, 16'h0004, 2'b11); rd(4, rv); chk("R9 boot cleared", rv, 0);

    // R11 kick and tick on the same edge
    do_reset();
    wr(2, 1, 2'b11);
    wr(1, 6, 2'b11);
    wr(0, 0, 2'b11);
    ticks(2);
    rd(0, rv); chk("R5 two ticks", rv, 4);
    tick_i = 1'b1; wr(0, 0, 2'b11); tick_i = 1'b0;
    rd(0, rv); chk("R11 reload wins", rv, 6);
    ticks(5);
    rd(0, rv); chk("R11 at one", rv, 1);
    tick_i = 1'b1; wr(0, 0, 2'b11); tick_i = 1'b0;
    chk("R11 no expiry", first_evt_o, 0);
    rd(3, rv); chk("R11 sts1 clear", rv, 0);
    rd(0, rv); chk("R11 count", rv, 6);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule